// File: doc/BRIEF.md
# Region of Interest Max Pooling Engine

This block pools one detection proposal at a time down to a fixed K×K grid of maxima for every feature channel. A proposal arrives as two corner points, each a pair of image-pixel coordinates. The engine maps those corners onto the coarser feature map. The feature map is smaller than the image by a power-of-two stride, so the mapping is a right shift. The start corner is rounded down and the end corner is rounded up. The mapped rectangle is then divided into K bins per axis, and the bin edges are derived with a small serial divider.

Feature values are signed 8-bit words. They are read from a synchronous on-chip memory through a single address/data port that has one cycle of read latency. For each bin the engine scans the cells of the bin once per channel and keeps a signed running maximum.

Results leave on a valid/ready stream. Each beat carries the maxima of LANES neighbouring channels for one bin, so that a downstream stage can consume several channels in parallel. The host side presents a proposal while the engine is idle. When the engine has sent the last beat of that proposal, it marks the end with a one-cycle done pulse.

Top module: `roi_pool_engine`

## Requirements
- R1: After reset, `busy`, `out_valid`, `done` and `mem_rd_en` are all low, and they stay low until a proposal is accepted.
- R2: When `busy` is low, a high `prop_valid` is taken at the clock edge, and `busy` is high from the next cycle.
- R3: While `busy` is high, `prop_valid` and the coordinate inputs are ignored. The current proposal's results are unchanged, and no second proposal starts after `done`.
- R4: Each axis is mapped with start = min(floor(lo / 2^SHIFT), N-1) and end = min(max(ceil(hi / 2^SHIFT), start+1), N). Here N is the feature map extent on that axis, so every mapped size is at least 1 and stays inside the map.
- R5: With size = end - start, bin i on an axis spans from start + floor(i·size/K) (inclusive) to start + ceil((i+1)·size/K) (exclusive).
- R6: The value for a bin and channel is the signed maximum of all feature values inside the bin.
- R7: Beats are ordered by channel group (channels g·LANES to g·LANES+LANES-1) first, then bin row, then bin column. Lane l of a beat sits in `out_data[l*DW +: DW]` and holds channel g·LANES+l.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: Each proposal yields exactly K·K·CH/LANES beats. `done` pulses for one cycle in the cycle after the last beat is taken, and `busy` is low in that cycle.
- R10: The read address for channel c, row y, column x is (c·FM_H + y)·FM_W + x. The data is used one cycle after `mem_rd_en`. Reads happen only while `busy` is high and always fall inside CH·FM_H·FM_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prop_valid | input | 1 | Proposal present |
| prop_x0 | input | COORD_W | Start corner column, image pixels |
| prop_y0 | input | COORD_W | Start corner row, image pixels |
| prop_x1 | input | COORD_W | End corner column, image pixels |
| prop_y1 | input | COORD_W | End corner row, image pixels |
| busy | output | 1 | Proposal in progress |
| mem_rd_en | output | 1 | Feature memory read strobe |
| mem_rd_addr | output | clog2(CH·FM_H·FM_W) | Feature memory read address |
| mem_rd_data | input | DW | Feature value, one cycle after the strobe |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | LANES·DW | Maxima of one bin for LANES channels |
| done | output | 1 | One-cycle end-of-proposal pulse |

## Verification
The timing of each result is fixed:

- `busy` is due one cycle after a proposal is accepted.
- Memory data is consumed one cycle after each strobe. The bench memory model answers on the next rising edge.
- A beat counts as taken at the edge where `out_valid` and `out_ready` are both high.
- `done` is due in the cycle right after the last beat is taken.

The bench drives its inputs at the falling edge. It sets `out_ready` first and only then samples. It counts a beat only when valid and ready are both high at that sample. It checks `busy` one cycle after each accept and checks `done` one cycle after the final handshake. Stall stability is compared between consecutive falling-edge samples.

// File: rtl/roi_pkg.sv
package roi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV,
        ST_SCAN,
        ST_DRAIN,
        ST_EMIT
    } roi_st_e;
endpackage

// File: rtl/roi_seqdiv.sv
// Restoring divider by a constant: one quotient bit per cycle.
module roi_seqdiv #(
    parameter int NUM_W   = 5,
    parameter int DIVISOR = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    output logic [NUM_W-1:0] quo,
    output logic [NUM_W-1:0] rem,
    output logic             done
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [NUM_W:0] DIV_V = (NUM_W + 1)'(DIVISOR);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic             done;
    } div_state_t;

    div_state_t d, q;
    logic [NUM_W:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.quo[NUM_W-1]};
        if (q.cnt != '0) begin
            if (trial >= DIV_V) begin
                d.rem = NUM_W'(trial - DIV_V);
                d.quo = {q.quo[NUM_W-2:0], 1'b1};
            end else begin
                d.rem = trial[NUM_W-1:0];
                d.quo = {q.quo[NUM_W-2:0], 1'b0};
            end
            d.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) d.done = 1'b1;
        end else if (start) begin
            d.cnt = CNT_W'(NUM_W);
            d.rem = '0;
            d.quo = num;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quo  = q.quo;
    assign rem  = q.rem;
    assign done = q.done;
endmodule

// File: rtl/roi_map.sv
// Image-to-feature coordinate mapping for one axis (power-of-two stride).
module roi_map #(
    parameter int COORD_W = 7,
    parameter int SHIFT   = 2,
    parameter int FM_N    = 8,
    parameter int IDX_W   = 4
) (
    input  logic [COORD_W-1:0] lo,
    input  logic [COORD_W-1:0] hi,
    output logic [IDX_W-1:0]   start,
    output logic [IDX_W-1:0]   size
);
    localparam int CW1 = COORD_W + 1;
    localparam logic [CW1-1:0] RND  = CW1'((1 << SHIFT) - 1);
    localparam logic [CW1-1:0] LAST = CW1'(FM_N - 1);
    localparam logic [CW1-1:0] LIM  = CW1'(FM_N);

    logic [CW1-1:0] fl, ce, st, en;

    always_comb begin
        fl = CW1'(lo) >> SHIFT;
        ce = (CW1'(hi) + RND) >> SHIFT;
        st = (fl > LAST) ? LAST : fl;
        en = (ce > st) ? ce : st + CW1'(1);
        if (en > LIM) en = LIM;
        start = IDX_W'(st);
        size  = IDX_W'(en - st);
    end
endmodule

// File: rtl/roi_pool_engine.sv
module roi_pool_engine
    import roi_pkg::*;
#(
    parameter int COORD_W = 7,
    parameter int SHIFT   = 2,
    parameter int FM_W    = 8,
    parameter int FM_H    = 6,
    parameter int CH      = 4,
    parameter int LANES   = 2,
    parameter int K       = 3,
    parameter int DW      = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               prop_valid,
    input  logic [COORD_W-1:0]                 prop_x0,
    input  logic [COORD_W-1:0]                 prop_y0,
    input  logic [COORD_W-1:0]                 prop_x1,
    input  logic [COORD_W-1:0]                 prop_y1,
    output logic                               busy,
    output logic                               mem_rd_en,
    output logic [$clog2(CH*FM_H*FM_W)-1:0]    mem_rd_addr,
    input  logic [DW-1:0]                      mem_rd_data,
    output logic                               out_valid,
    input  logic                               out_ready,
    output logic [LANES*DW-1:0]                out_data,
    output logic                               done
);
    localparam int FM_MAX = (FM_W > FM_H) ? FM_W : FM_H;
    localparam int IDX_W  = $clog2(FM_MAX + 1);
    localparam int NUM_W  = $clog2(K * FM_MAX + 1);
    localparam int BIN_W  = $clog2(K + 1);
    localparam int NGRP   = CH / LANES;
    localparam int GRP_W  = $clog2(NGRP + 1);
    localparam int LANE_W = $clog2(LANES + 1);
    localparam int ADDR_W = $clog2(CH * FM_H * FM_W);
    localparam int OUT_W  = LANES * DW;
    localparam logic [ADDR_W-1:0] FMW_A = ADDR_W'(FM_W);
    localparam logic [ADDR_W-1:0] FMH_A = ADDR_W'(FM_H);
    localparam logic [ADDR_W-1:0] LNS_A = ADDR_W'(LANES);
    localparam logic [DW-1:0]     MINV  = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        roi_st_e                  st;
        logic [IDX_W-1:0]         sx, wx, sy, wy;
        logic [IDX_W-1:0]         ys, ye, xs, xe;
        logic [IDX_W-1:0]         cy, cx;
        logic [BIN_W-1:0]         by, bx;
        logic [GRP_W-1:0]         grp;
        logic [1:0]               dsel;
        logic                     drun;
        logic [LANE_W-1:0]        lane, plane;
        logic                     pend;
        logic [LANES-1:0][DW-1:0] acc;
        logic                     done;
    } eng_state_t;

    eng_state_t d, q;

    logic [IDX_W-1:0] mx_start, mx_size, my_start, my_size;
    logic             div_start, div_done;
    logic [NUM_W-1:0] div_num, div_quo, div_rem, div_ceil, mul_a, mul_b;
    logic [IDX_W-1:0] base, bound_f, bound_c;
    logic [ADDR_W-1:0] ch_a;

    roi_map #(.COORD_W(COORD_W), .SHIFT(SHIFT), .FM_N(FM_W), .IDX_W(IDX_W)) map_x_i (
        .lo(prop_x0), .hi(prop_x1), .start(mx_start), .size(mx_size));
    roi_map #(.COORD_W(COORD_W), .SHIFT(SHIFT), .FM_N(FM_H), .IDX_W(IDX_W)) map_y_i (
        .lo(prop_y0), .hi(prop_y1), .start(my_start), .size(my_size));

    roi_seqdiv #(.NUM_W(NUM_W), .DIVISOR(K)) div_i (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
        .quo(div_quo), .rem(div_rem), .done(div_done));

    always_comb begin
        // Divider operand: edge index times mapped size, per bound in turn.
        case (q.dsel)
            2'd0:    begin mul_a = NUM_W'(q.by);                  mul_b = NUM_W'(q.wy); end
            2'd1:    begin mul_a = NUM_W'(q.by) + NUM_W'(1);      mul_b = NUM_W'(q.wy); end
            2'd2:    begin mul_a = NUM_W'(q.bx);                  mul_b = NUM_W'(q.wx); end
            default: begin mul_a = NUM_W'(q.bx) + NUM_W'(1);      mul_b = NUM_W'(q.wx); end
        endcase
        div_num  = mul_a * mul_b;
        div_ceil = div_quo + NUM_W'(div_rem != '0);
        base     = q.dsel[1] ? q.sx : q.sy;
        bound_f  = base + IDX_W'(div_quo);
        bound_c  = base + IDX_W'(div_ceil);
        ch_a     = ADDR_W'(q.grp) * LNS_A + ADDR_W'(q.lane);
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.pend    = 1'b0;
        div_start = 1'b0;

        // Fold the value returned for last cycle's read into its lane.
        if (q.pend) begin
            for (int l = 0; l < LANES; l++) begin
                if (q.plane == LANE_W'(l) &&
                    $signed(mem_rd_data) > $signed(q.acc[l]))
                    d.acc[l] = mem_rd_data;
            end
        end

        case (q.st)
            ST_IDLE: begin
                if (prop_valid) begin
                    d.sx   = mx_start;
                    d.wx   = mx_size;
                    d.sy   = my_start;
                    d.wy   = my_size;
                    d.by   = '0;
                    d.bx   = '0;
                    d.grp  = '0;
                    d.dsel = '0;
                    d.drun = 1'b0;
                    d.st   = ST_DIV;
                end
            end
            ST_DIV: begin
                if (!q.drun) begin
                    div_start = 1'b1;
                    d.drun    = 1'b1;
                end else if (div_done) begin
                    d.drun = 1'b0;
                    d.dsel = q.dsel + 2'd1;
                    case (q.dsel)
                        2'd0: d.ys = bound_f;
                        2'd1: d.ye = bound_c;
                        2'd2: d.xs = bound_f;
                        default: begin
                            d.xe   = bound_c;
                            d.lane = '0;
                            d.cy   = q.ys;
                            d.cx   = q.xs;
                            if (q.ys >= q.ye || q.xs >= bound_c) begin
                                d.acc = '0;  // empty bin reports zero
                                d.st  = ST_EMIT;
                            end else begin
                                for (int l = 0; l < LANES; l++) d.acc[l] = MINV;
                                d.st = ST_SCAN;
                            end
                        end
                    endcase
                end
            end
            ST_SCAN: begin
                d.pend  = 1'b1;
                d.plane = q.lane;
                if (q.cx == q.xe - IDX_W'(1)) begin
                    d.cx = q.xs;
                    if (q.cy == q.ye - IDX_W'(1)) begin
                        d.cy = q.ys;
                        if (q.lane == LANE_W'(LANES - 1)) d.st = ST_DRAIN;
                        else d.lane = q.lane + LANE_W'(1);
                    end else begin
                        d.cy = q.cy + IDX_W'(1);
                    end
                end else begin
                    d.cx = q.cx + IDX_W'(1);
                end
            end
            ST_DRAIN: d.st = ST_EMIT;
            ST_EMIT: begin
                if (out_ready) begin
                    d.st   = ST_DIV;
                    d.dsel = '0;
                    d.drun = 1'b0;
                    if (q.bx == BIN_W'(K - 1)) begin
                        d.bx = '0;
                        if (q.by == BIN_W'(K - 1)) begin
                            d.by = '0;
                            if (q.grp == GRP_W'(NGRP - 1)) begin
                                d.st   = ST_IDLE;
                                d.done = 1'b1;
                            end else begin
                                d.grp = q.grp + GRP_W'(1);
                            end
                        end else begin
                            d.by = q.by + BIN_W'(1);
                        end
                    end else begin
                        d.bx = q.bx + BIN_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.st != ST_IDLE);
    assign mem_rd_en   = (q.st == ST_SCAN);
    assign mem_rd_addr = (ch_a * FMH_A + ADDR_W'(q.cy)) * FMW_A + ADDR_W'(q.cx);
    assign out_valid   = (q.st == ST_EMIT);
    assign out_data    = OUT_W'(q.acc);
    assign done        = q.done;
endmodule

// File: rtl/roi_pool_engine_chk.sv
module roi_pool_engine_chk #(
    parameter int ADDR_W = 8,
    parameter int OUT_W  = 16,
    parameter int DEPTH  = 192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prop_valid,
    input logic              busy,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_W-1:0]  out_data,
    input logic              done
);
    localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W + 1)'(DEPTH);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !out_valid));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_valid && !busy) |=> busy);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_addr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ({1'b0, mem_rd_addr} < DEPTH_V));
endmodule

bind roi_pool_engine roi_pool_engine_chk #(
    .ADDR_W(ADDR_W), .OUT_W(OUT_W), .DEPTH(CH * FM_H * FM_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .prop_valid(prop_valid), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done)
);

// File: tb/roi_pool_engine_tb.sv
module roi_pool_engine_tb_top;
    localparam int COORD_W = 7;
    localparam int SHIFT   = 2;
    localparam int FM_W    = 8;
    localparam int FM_H    = 6;
    localparam int CH      = 4;
    localparam int LANES   = 2;
    localparam int K       = 3;
    localparam int DW      = 8;
    localparam int DEPTH   = CH * FM_H * FM_W;
    localparam int ADDR_W  = $clog2(DEPTH);
    localparam int NB      = K * K * CH / LANES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prop_valid = 1'b0;
    logic [COORD_W-1:0] prop_x0 = '0, prop_y0 = '0, prop_x1 = '0, prop_y1 = '0;
    logic busy, mem_rd_en, out_valid, done;
    logic out_ready = 1'b0;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data = '0;
    logic [LANES*DW-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int bad_addr = 0;

    always #5 clk = ~clk;

    roi_pool_engine #(.COORD_W(COORD_W), .SHIFT(SHIFT), .FM_W(FM_W), .FM_H(FM_H),
                      .CH(CH), .LANES(LANES), .K(K), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .prop_valid(prop_valid),
        .prop_x0(prop_x0), .prop_y0(prop_y0), .prop_x1(prop_x1), .prop_y1(prop_y1),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done));

    function automatic int fval(input int c, input int y, input int x);
        return ((c * 53 + y * 29 + x * 71 + y * x * 13) % 256) - 128;
    endfunction

    // Feature memory: synchronous read, address = (c*FM_H + y)*FM_W + x (R10).
    always @(posedge clk) begin
        if (mem_rd_en) begin
            int a;
            a = int'(mem_rd_addr);
            if (a >= DEPTH || !busy) bad_addr++;
            mem_rd_data <= DW'(fval(a / (FM_H * FM_W), (a % (FM_H * FM_W)) / FM_W, a % FM_W));
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Axis mapping per R4.
    task automatic map_axis(input int lo, input int hi, input int n, output int st, output int sz);
        int en;
        st = lo / (1 << SHIFT);
        if (st > n - 1) st = n - 1;
        en = (hi + (1 << SHIFT) - 1) / (1 << SHIFT);
        if (en <= st) en = st + 1;
        if (en > n) en = n;
        sz = en - st;
    endtask

    function automatic logic [LANES*DW-1:0] expect_beat(input int n, input int sxs, input int sxz,
                                                        input int sys, input int syz);
        logic [LANES*DW-1:0] v;
        int g, b, by, bx, ys, ye, xs, xe;
        g  = n / (K * K);
        b  = n % (K * K);
        by = b / K;
        bx = b % K;
        ys = sys + (by * syz) / K;
        ye = sys + ((by + 1) * syz + K - 1) / K;
        xs = sxs + (bx * sxz) / K;
        xe = sxs + ((bx + 1) * sxz + K - 1) / K;
        v = '0;
        for (int l = 0; l < LANES; l++) begin
            int m;
            m = -128;
            for (int y = ys; y < ye; y++)
                for (int x = xs; x < xe; x++)
                    if (fval(g * LANES + l, y, x) > m) m = fval(g * LANES + l, y, x);
            v[l*DW +: DW] = DW'(m);
        end
        return v;
    endfunction

    task automatic run_prop(input int x0, input int y0, input int x1, input int y1, input bit inject);
        int sxs, sxz, sys, syz, beats, cyc, bad_stall, addr0;
        bit seen_done, prev_last, stall_pend;
        logic [LANES*DW-1:0] stall_data, exp;
        map_axis(x0, x1, FM_W, sxs, sxz);
        map_axis(y0, y1, FM_H, sys, syz);
        addr0 = bad_addr;
        @(negedge clk);
        prop_x0 = COORD_W'(x0); prop_y0 = COORD_W'(y0);
        prop_x1 = COORD_W'(x1); prop_y1 = COORD_W'(y1);
        prop_valid = 1'b1;
        @(negedge clk);
        prop_valid = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", longint'(busy), 1);
        beats = 0; cyc = 0; bad_stall = 0;
        seen_done = 1'b0; prev_last = 1'b0; stall_pend = 1'b0; stall_data = '0;
        while (!seen_done) begin
            out_ready = ((x0 % 2) == 0) ? 1'b1 : ((cyc % 4) != 3);
            if (inject && cyc == 15) begin
                prop_valid = 1'b1;
                prop_x0 = '0; prop_y0 = '0; prop_x1 = '1; prop_y1 = '1;
            end else begin
                prop_valid = 1'b0;
            end
            #1;
            if (done) begin
                seen_done = 1'b1;
                check(beats == NB && prev_last, "R9 done after last beat", longint'(beats), NB);
                check(!busy, "R9 busy low with done", longint'(busy), 0);
            end
            prev_last = 1'b0;
            if (stall_pend && (!out_valid || out_data != stall_data)) bad_stall++;
            stall_pend = out_valid && !out_ready;
            stall_data = out_data;
            if (out_valid && out_ready) begin
                if (beats < NB) begin
                    exp = expect_beat(beats, sxs, sxz, sys, syz);
                    check(out_data == exp,
                          inject ? "R3 R4 R5 R6 R7 beat" : "R4 R5 R6 R7 beat",
                          longint'(out_data), longint'(exp));
                end else begin
                    check(1'b0, "R9 extra beat", longint'(beats), NB);
                end
                beats++;
                if (beats == NB) prev_last = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        prop_valid = 1'b0;
        out_ready = 1'b0;
        check(bad_stall == 0, "R8 stall stability", longint'(bad_stall), 0);
        check(bad_addr == addr0, "R10 read address range", longint'(bad_addr - addr0), 0);
        @(negedge clk);
        check(!busy && !out_valid, "R3 no restart after done", longint'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: done never arrived");
        summary();
        $finish;
    end

    initial begin
        int xs_l[5] = '{0, 5, 13, 30, 40};
        int xe_l[5] = '{3, 9, 22, 31, 60};
        int ys_l[5] = '{0, 2, 7, 17, 26};
        int ye_l[5] = '{1, 6, 12, 23, 50};
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !out_valid && !done && !mem_rd_en, "R1 reset outputs",
              longint'({busy, out_valid, done, mem_rd_en}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !out_valid && !done && !mem_rd_en, "R1 idle after reset",
              longint'({busy, out_valid, done, mem_rd_en}), 0);
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                run_prop(xs_l[i], ys_l[(i + j) % 5], xe_l[j], ye_l[(i + 2 * j) % 5], (i + j) == 3);
        run_prop(6, 6, 6, 6, 1'b0);        // sub-cell region, R4 minimum size
        run_prop(20, 20, 4, 4, 1'b0);      // reversed corners
        run_prop(0, 0, 127, 127, 1'b1);    // whole map, clamped
        run_prop(127, 127, 127, 127, 1'b0); // start beyond map
        summary();
        $finish;
    end
endmodule